// File: doc/BRIEF.md
# Serially Addressed Debug Probe and Control Decoder

This block holds a 12-bit debug address that a host builds one bit at a time. Each strobe with shifting enabled moves the address up by one place and puts the host's bit into the bottom. The low 11 bits of the address choose one of up to 2048 observation signals. A tree of 8-to-1 selectors funnels the chosen signal onto a single read-back pin. That pin depends only on the address and the observation inputs.

The same address can also act as a command. While the host holds the control-enable flag, every strobe decodes the full 12-bit address as it stood before that strobe. A matching command writes the address's low bits into one of four small side registers: parity-halt enables, an 8-bit clock-rate value, run enables and power-on bits. The clock-rate value is also presented as a multiplier (rate + 1) for an external clock synthesiser.

The decode repeats on every strobe for as long as the flag stays set, so the host must drop the flag straight after the command it wants. A host that steps the shift input with the XOR of address bits 10 and 8 sweeps every nonzero 11-bit address exactly once in 2047 strobes.

Top module: `dbg_probe_ctl`

## Requirements
- R1: After reset the address and all side registers (parity enables, rate, run enables, power bits) read zero, and the multiplier reads 1.
- R2: A strobe with `shift_en` high sets `dbg_addr` to {previous `dbg_addr`[10:0], `shift_bit`}. A strobe with `shift_en` low leaves the address unchanged.
- R3: `rd_bit` equals `obs[dbg_addr[10:0]]`. Address bit 11 has no effect on the readout.
- R4: A control strobe whose pre-strobe address is in 12'h000–12'h03F (octal 0000–0077) loads `pe_halt_en` with address bits [5:0].
- R5: A control strobe whose address is in 12'h480–12'h48F (octal 2200–2217) loads `clk_rate[7:4]` from address bits [3:0] and leaves `clk_rate[3:0]` unchanged.
- R6: A control strobe whose address is in 12'h490–12'h49F (octal 2220–2237) loads `clk_rate[3:0]` from address bits [3:0] and leaves `clk_rate[7:4]` unchanged.
- R7: A control strobe whose address is in 12'h4A0–12'h4AF (octal 2240–2257) loads `run_en` with address bits [3:0].
- R8: A control strobe whose address is in 12'h4C0–12'h4CF (octal 2300–2317) loads `pwr_on` with address bits [3:0].
- R9: A strobe with `ctl_en` low, or a control strobe at any address outside the ranges above, changes no side register.
- R10: When a strobe both shifts and decodes, the decode uses the address held before that strobe. Each further strobe with `ctl_en` high decodes again.
- R11: `clk_mult` equals `clk_rate` + 1, as a 9-bit value.
- R12: Starting from address zero, shifting in 1 and then, on each step, the XOR of 11-bit address bits 10 and 8 visits all 2047 nonzero 11-bit addresses once each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle host strobe |
| shift_en | input | 1 | Strobe shifts `shift_bit` into the address |
| shift_bit | input | 1 | Serial address bit |
| ctl_en | input | 1 | Strobe decodes the address as a control function |
| obs | input | 2048 | Observation signals |
| rd_bit | output | 1 | Selected observation signal |
| dbg_addr | output | 12 | Current address register |
| pe_halt_en | output | 6 | Parity-halt enable bits |
| clk_rate | output | 8 | Clock-rate value |
| clk_mult | output | 9 | Reference multiplier, `clk_rate` + 1 |
| run_en | output | 4 | Run enable bits |
| pwr_on | output | 4 | Power-on bits |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 2048 observation inputs. At that size the whole 2047-step feedback sweep and the full four-level selector tree can be run in one test. Each step is checked against a bench-computed pattern, and a visit table confirms that no address repeats. The same configuration also reaches every control range at its edges and the rate's all-ones case, where the multiplier carries into bit 8.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    CF_NONE,
    CF_PE,
    CF_RATE_HI,
    CF_RATE_LO,
    CF_RUN,
    CF_PWR
  } ctl_fn_e;

  localparam logic [ADDR_W-1:0] PE_BASE      = 12'o0000;
  localparam logic [ADDR_W-1:0] RATE_HI_BASE = 12'o2200;
  localparam logic [ADDR_W-1:0] RATE_LO_BASE = 12'o2220;
  localparam logic [ADDR_W-1:0] RUN_BASE     = 12'o2240;
  localparam logic [ADDR_W-1:0] PWR_BASE     = 12'o2300;

  function automatic ctl_fn_e classify(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:6] == PE_BASE[ADDR_W-1:6])           return CF_PE;
    else if (a[ADDR_W-1:4] == RATE_HI_BASE[ADDR_W-1:4]) return CF_RATE_HI;
    else if (a[ADDR_W-1:4] == RATE_LO_BASE[ADDR_W-1:4]) return CF_RATE_LO;
    else if (a[ADDR_W-1:4] == RUN_BASE[ADDR_W-1:4])     return CF_RUN;
    else if (a[ADDR_W-1:4] == PWR_BASE[ADDR_W-1:4])     return CF_PWR;
    else                                                return CF_NONE;
  endfunction
endpackage

// File: rtl/dbgm_shift_reg.sv
module dbgm_shift_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (step) addr_q <= {addr_q[W-2:0], din};
  end

  // R2: no strobe-with-shift, no movement
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(addr_q));
endmodule

// File: rtl/dbgm_mux8.sv
module dbgm_mux8 (
  input  logic [7:0] d,
  input  logic [2:0] s,
  output logic       y
);
  assign y = d[s];
endmodule

// File: rtl/dbgm_sel_tree.sv
module dbgm_sel_tree #(
  parameter int SEL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [(1<<SEL_W)-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             rd
);
  localparam int N_IN   = 1 << SEL_W;
  localparam int LEVELS = (SEL_W + 2) / 3;
  localparam int PSEL_W = 3 * LEVELS;
  localparam int PAD    = 1 << PSEL_W;

  logic [PAD-1:0]    src_pad;
  logic [PSEL_W-1:0] sel_pad;

  generate
    if (PAD > N_IN) begin : g_pad_src
      assign src_pad = {{(PAD-N_IN){1'b0}}, src};
    end else begin : g_full_src
      assign src_pad = src;
    end
    if (PSEL_W > SEL_W) begin : g_pad_sel
      assign sel_pad = {{(PSEL_W-SEL_W){1'b0}}, sel};
    end else begin : g_full_sel
      assign sel_pad = sel;
    end

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lv
      localparam int IN_N  = PAD >> (3*lv);
      localparam int OUT_N = IN_N / 8;
      logic [IN_N-1:0]  din;
      logic [OUT_N-1:0] dout;
      if (lv == 0) begin : g_first
        assign din = src_pad;
      end else begin : g_next
        assign din = g_lv[lv-1].dout;
      end
      for (genvar g = 0; g < OUT_N; g++) begin : g_mux
        dbgm_mux8 u_mux (
          .d (din[8*g +: 8]),
          .s (sel_pad[3*lv +: 3]),
          .y (dout[g])
        );
      end
    end
  endgenerate

  assign rd = g_lv[LEVELS-1].dout[0];

  // R3: tree output agrees with a flat index of the sources
  assert_tree_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd == src[sel]);
endmodule

// File: rtl/dbgm_ctl_decode.sv
module dbgm_ctl_decode
  import dbgm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] cmd,
  output logic [5:0]        pe_q,
  output logic [7:0]        rate_q,
  output logic [3:0]        run_q,
  output logic [3:0]        pwr_q
);
  ctl_fn_e fn;
  assign fn = classify(cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_q   <= '0;
      rate_q <= '0;
      run_q  <= '0;
      pwr_q  <= '0;
    end else if (fire) begin
      unique case (fn)
        CF_PE:      pe_q        <= cmd[5:0];
        CF_RATE_HI: rate_q[7:4] <= cmd[3:0];
        CF_RATE_LO: rate_q[3:0] <= cmd[3:0];
        CF_RUN:     run_q       <= cmd[3:0];
        CF_PWR:     pwr_q       <= cmd[3:0];
        default:    ;
      endcase
    end
  end

  // R5/R6: one strobe touches at most one side register group
  assert_one_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $onehot0({pe_q != $past(pe_q), rate_q[7:4] != $past(rate_q[7:4]),
                       rate_q[3:0] != $past(rate_q[3:0]), run_q != $past(run_q),
                       pwr_q != $past(pwr_q)}));
endmodule

// File: rtl/dbg_probe_ctl.sv
module dbg_probe_ctl
  import dbgm_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int SEL_W = AW - 1,
  parameter int N_SIG = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic             ctl_en,
  input  logic [N_SIG-1:0] obs,
  output logic             rd_bit,
  output logic [AW-1:0]    dbg_addr,
  output logic [5:0]       pe_halt_en,
  output logic [7:0]       clk_rate,
  output logic [8:0]       clk_mult,
  output logic [3:0]       run_en,
  output logic [3:0]       pwr_on
);
  logic step, fire;
  assign step = strobe & shift_en;
  assign fire = strobe & ctl_en;

  dbgm_shift_reg #(.W(AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .din    (shift_bit),
    .addr_q (dbg_addr)
  );

  dbgm_sel_tree #(.SEL_W(SEL_W)) u_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (obs),
    .sel   (dbg_addr[SEL_W-1:0]),
    .rd    (rd_bit)
  );

  dbgm_ctl_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .cmd    (dbg_addr),
    .pe_q   (pe_halt_en),
    .rate_q (clk_rate),
    .run_q  (run_en),
    .pwr_q  (pwr_on)
  );

  assign clk_mult = {1'b0, clk_rate} + 9'd1;

  // R9: side registers hold unless a control strobe arrives
  assert_side_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(pe_halt_en) && $stable(clk_rate) && $stable(run_en) && $stable(pwr_on)));

  // R7 and R10: run range decodes the pre-strobe address
  assert_run_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dbg_addr[AW-1:4] == RUN_BASE[AW-1:4]) |=> run_en == $past(dbg_addr[3:0]));

  // R8
  assert_pwr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dbg_addr[AW-1:4] == PWR_BASE[AW-1:4]) |=> pwr_on == $past(dbg_addr[3:0]));
endmodule

// File: tb/dbg_probe_ctl_tb.sv
module dbg_probe_ctl_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic strobe = 0, shift_en = 0, shift_bit = 0, ctl_en = 0;
  logic [2047:0] obs;
  logic rd_bit;
  logic [11:0] dbg_addr;
  logic [5:0] pe_halt_en;
  logic [7:0] clk_rate;
  logic [8:0] clk_mult;
  logic [3:0] run_en, pwr_on;

  int total = 0, bad = 0;
  logic [11:0] m_addr;
  bit seen [2048];

  always #5 clk = ~clk;

  dbg_probe_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .shift_en(shift_en),
    .shift_bit(shift_bit), .ctl_en(ctl_en), .obs(obs), .rd_bit(rd_bit),
    .dbg_addr(dbg_addr), .pe_halt_en(pe_halt_en), .clk_rate(clk_rate),
    .clk_mult(clk_mult), .run_en(run_en), .pwr_on(pwr_on)
  );

  function automatic bit pat(int i);
    return ((i * 97 + (i >> 3)) % 7) < 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit sh, input bit b, input bit c);
    @(negedge clk);
    shift_en = sh; shift_bit = b; ctl_en = c; strobe = 1;
    @(negedge clk);
    strobe = 0; shift_en = 0; ctl_en = 0;
    if (sh) m_addr = {m_addr[10:0], b};
  endtask

  task automatic load(input logic [11:0] a);
    for (int i = 11; i >= 0; i--) pulse(1, a[i], 0);
  endtask

  task automatic side_chk(input string req, input int pe, input int rt, input int rn, input int pw);
    check(pe_halt_en == pe, req, pe_halt_en, pe);
    check(clk_rate == rt, req, clk_rate, rt);
    check(run_en == rn, req, run_en, rn);
    check(pwr_on == pw, req, pwr_on, pw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int visits;
    for (int i = 0; i < 2048; i++) obs[i] = pat(i);
    m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(dbg_addr == 0, "R1", dbg_addr, 0);
    side_chk("R1", 0, 0, 0, 0);
    check(clk_mult == 1, "R1", clk_mult, 1);

    // R2 shifting and holding
    load(12'hA5C);
    check(dbg_addr == 12'hA5C, "R2", dbg_addr, 12'hA5C);
    pulse(0, 1, 0);
    check(dbg_addr == 12'hA5C, "R2 hold", dbg_addr, 12'hA5C);

    // R12 / R3: full feedback sweep
    load(12'h000);
    check(rd_bit == pat(0), "R3", rd_bit, pat(0));
    for (int i = 0; i < 2048; i++) seen[i] = 0;
    visits = 0;
    for (int s = 0; s < 2047; s++) begin
      bit nb;
      nb = (s == 0) ? 1'b1 : (m_addr[10] ^ m_addr[8]);
      pulse(1, nb, 0);
      check(dbg_addr == m_addr, "R2 sweep", dbg_addr, m_addr);
      check(rd_bit == pat(int'(m_addr[10:0])), "R3 sweep", rd_bit, pat(int'(m_addr[10:0])));
      if (m_addr[10:0] != 0 && !seen[m_addr[10:0]]) visits++;
      check(!seen[m_addr[10:0]] && m_addr[10:0] != 0, "R12 repeat", m_addr[10:0], 0);
      seen[m_addr[10:0]] = 1;
    end
    check(visits == 2047, "R12 coverage", visits, 2047);
    side_chk("R9 sweep", 0, 0, 0, 0);

    // R3: bit 11 ignored, one-hot source
    obs = '0; obs[5] = 1'b1;
    load(12'h805);
    check(rd_bit == 1, "R3 bit11", rd_bit, 1);
    load(12'h005);
    check(rd_bit == 1, "R3", rd_bit, 1);
    load(12'h006);
    check(rd_bit == 0, "R3", rd_bit, 0);
    obs = '0; obs[2047] = 1'b1;
    load(12'h7FF);
    check(rd_bit == 1, "R3 top", rd_bit, 1);

    // R9: address in range but no control flag
    load(12'h4A7);
    pulse(0, 0, 0);
    side_chk("R9", 0, 0, 0, 0);

    // R4
    load(12'h02A);
    pulse(0, 0, 1);
    side_chk("R4", 6'h2A, 0, 0, 0);
    load(12'h03F);
    pulse(0, 0, 1);
    side_chk("R4 edge", 6'h3F, 0, 0, 0);

    // R9: unmapped addresses
    load(12'h040); pulse(0, 0, 1);
    load(12'h4B3); pulse(0, 0, 1);
    load(12'h47F); pulse(0, 0, 1);
    side_chk("R9 unmapped", 6'h3F, 0, 0, 0);

    // R5 / R6 / R11
    load(12'h48B); pulse(0, 0, 1);
    side_chk("R5", 6'h3F, 8'hB0, 0, 0);
    check(clk_mult == 9'h0B1, "R11", clk_mult, 9'h0B1);
    load(12'h496); pulse(0, 0, 1);
    side_chk("R6", 6'h3F, 8'hB6, 0, 0);
    load(12'h48F); pulse(0, 0, 1);
    load(12'h49F); pulse(0, 0, 1);
    check(clk_rate == 8'hFF, "R5 R6", clk_rate, 8'hFF);
    check(clk_mult == 9'h100, "R11 carry", clk_mult, 9'h100);

    // R7 / R8
    load(12'h4AC); pulse(0, 0, 1);
    side_chk("R7", 6'h3F, 8'hFF, 4'hC, 0);
    load(12'h4C9); pulse(0, 0, 1);
    side_chk("R8", 6'h3F, 8'hFF, 4'hC, 4'h9);

    // R10: decode uses pre-shift address; repeats while flag set
    load(12'h4A5);
    pulse(1, 0, 1);
    check(run_en == 4'h5, "R10", run_en, 5);
    check(dbg_addr == 12'h94A, "R10 addr", dbg_addr, 12'h94A);
    pulse(1, 0, 1);
    side_chk("R10 repeat", 6'h3F, 8'hFF, 4'h5, 4'h9);
    load(12'h4C3);
    pulse(0, 0, 1);
    pulse(0, 0, 1);
    check(pwr_on == 4'h3, "R10 repeat", pwr_on, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule